// File: doc/BRIEF.md
# Monitor Channel Handshake Transmitter

This block sends a message of one or more bytes across a time-division bus that carries one byte-wide monitor slot in every frame. The bit clock shifts out the eight data bits of the slot, MSB first, and then one transmit-enable bit (MX). The far side answers on its own line with a receive-acknowledge bit (MR). Both lines are open-drain. A zero data bit and an active handshake bit pull the line low, so a released line reads as one and a handshake bit that nobody drives reads as inactive.

Bytes arrive on a valid/ready byte port, with a flag on the last byte of a message. The block keeps sending the current byte in every frame until the far side acknowledges it. It signals each new byte by releasing MX for exactly one frame. When the last byte is acknowledged it releases MX for two frames to close the message. The block reads back every bit it drives on its own line, and it counts frames while it waits for an acknowledge. It aborts on a collision, on a broken MR sequence, on time-out, or when the far end asks to abort. It reports the outcome as a one-cycle done or abort pulse, together with a 2-bit cause.

Top module: `mon_tx_handshake`

## Requirements
- R1: After reset the transmit line is released (`tx_pull` low), `done_o` and `abort_o` are low, `abort_cause` is 0 and `in_ready` is low until a frame starts.
- R2: In a slot the data bits sit at frame bit positions SLOT_POS to SLOT_POS+7, MSB first, and MX sits at SLOT_POS+8. A 0 data bit and an active MX pull the line low. The block never pulls the line outside these nine positions. MR is read at position MR_POS of the receive line, where low means active.
- R3: When idle, a byte offered at a frame start (the `fsync` cycle) is accepted, and it appears in that same frame with MX active.
- R4: The current byte is repeated in every frame until it is acknowledged. If an acknowledged byte is not the last and no next byte is offered, the byte stays repeated with MX active (stall).
- R5: After an acknowledge, the next byte goes out in the following frame with MX inactive for exactly that one frame, and with MX active after it.
- R6: The first byte counts as acknowledged when MR is active in a frame. Each later byte counts as acknowledged when MR has been inactive for one frame and is active again.
- R7: After the last byte is acknowledged, the slot stays released (0xFF, MX inactive) for two frames. `done_o` then pulses once early in the following frame.
- R8: MR inactive in two consecutive frames after it dropped (while waiting for an acknowledge, or during a stall) aborts the message with cause 3 (far-end abort).
- R9: MR inactive in the frame in which MX was released for a new byte, or an MR drop of a single frame during a stall, aborts the message with cause 0 (handshake error).
- R10: Any driven slot bit that reads back differently aborts at once with cause 1 (collision). The line is released from the next bit on, and the byte is not sent again.
- R11: With `timeout_frames` = N > 0, the block aborts with cause 2 at the N-th frame start counted since the byte was first sent without an acknowledge. Every acknowledge restarts the count. N = 0 turns the time-out off.
- R12: `abort_o` is a one-cycle pulse. `abort_cause` changes only with that pulse and otherwise holds the cause of the latest abort.
- R13: `in_ready` is high only in a frame-start cycle in which a byte can be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | High during bit 0 of each frame |
| tx_line_in | input | 1 | Level read back from the transmit line |
| rx_line_in | input | 1 | Level of the receive line (MR at MR_POS) |
| timeout_frames | input | TO_W | Time-out limit in frames, 0 turns it off |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Offered byte |
| in_last | input | 1 | Offered byte ends the message |
| in_ready | output | 1 | Byte taken this cycle when valid |
| tx_pull | output | 1 | Pull the transmit line low |
| done_o | output | 1 | Message completed (pulse) |
| abort_o | output | 1 | Message aborted (pulse) |
| abort_cause | output | 2 | Latest abort cause: 0 handshake, 1 collision, 2 time-out, 3 far-end |

## Verification
The hardest states to reach are the ones that need the far side to break or stretch the protocol at exactly the right frame. These are a single-frame MR drop during a stall, two MR drops after the toggle handshake, and a time-out that an acknowledge halfway through the wait has restarted. The bench plays the far side from a script that gives the MR level for each frame and how many bytes the source has ready. It can also pull the transmit line low at a chosen bit of a chosen frame to force a collision. It decodes each frame's slot from the line itself.

// File: rtl/mon_tx_pkg.sv
`timescale 1ns/1ps
package mon_tx_pkg;

  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned SLOT_BITS = BYTE_BITS + 1;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FIRST,
    S_TOGGLE,
    S_WAIT_DROP,
    S_WAIT_RISE,
    S_HOLD,
    S_HOLD_ERR,
    S_EOM1,
    S_EOM2
  } hs_state_e;

  typedef enum logic [1:0] {
    CAUSE_HANDSHAKE = 2'd0,
    CAUSE_COLLISION = 2'd1,
    CAUSE_TIMEOUT   = 2'd2,
    CAUSE_FAR_ABORT = 2'd3
  } abort_cause_e;

endpackage

// File: rtl/mon_frame_timer.sv
`timescale 1ns/1ps
module mon_frame_timer #(
  parameter int FRAME_BITS = 16,
  parameter int SLOT_POS   = 2,
  parameter int MR_POS     = 12,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic             frame_start,
  output logic             in_slot,
  output logic [CNT_W-1:0] slot_pos,
  output logic             mr_strobe
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] SLOT_LO  = CNT_W'(SLOT_POS);
  localparam logic [CNT_W-1:0] SLOT_HI  = CNT_W'(SLOT_POS + int'(mon_tx_pkg::SLOT_BITS) - 1);
  localparam logic [CNT_W-1:0] MR_IDX   = CNT_W'(MR_POS);

  logic [CNT_W-1:0] cnt_q, cur_idx;
  logic             synced_q, synced_d;

  // index of the bit currently on the line
  always_comb begin
    if (fsync)                 cur_idx = '0;
    else if (cnt_q == LAST_IDX) cur_idx = cnt_q;
    else                       cur_idx = cnt_q + 1'b1;
    synced_d = synced_q | fsync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= LAST_IDX;
      synced_q <= 1'b0;
    end else begin
      cnt_q    <= cur_idx;
      synced_q <= synced_d;
    end
  end

  assign frame_start = fsync;
  assign in_slot     = synced_d && (cur_idx >= SLOT_LO) && (cur_idx <= SLOT_HI);
  assign slot_pos    = cur_idx - SLOT_LO;
  assign mr_strobe   = synced_d && (cur_idx == MR_IDX);

  AST_MARKERS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_start, in_slot, mr_strobe})); // R2

endmodule

// File: rtl/mon_slot_driver.sv
`timescale 1ns/1ps
module mon_slot_driver #(
  parameter int CNT_W = 4
) (
  input  logic             in_slot,
  input  logic [CNT_W-1:0] slot_pos,
  input  logic             sending,
  input  logic             mx_act,
  input  logic [7:0]       byte_val,
  input  logic             line_in,
  output logic             pull,
  output logic             collision
);

  localparam logic [CNT_W-1:0] MX_POS = CNT_W'(mon_tx_pkg::BYTE_BITS);

  logic [2:0] bit_sel;
  logic       exp_level;

  always_comb begin
    bit_sel = 3'd7 - slot_pos[2:0];
    pull    = 1'b0;
    if (in_slot && sending) begin
      if (slot_pos < MX_POS) pull = ~byte_val[bit_sel];
      else                   pull = mx_act;
    end
    exp_level = ~pull;
    collision = in_slot && sending && (line_in != exp_level);
  end

endmodule

// File: rtl/mon_frame_timeout.sv
`timescale 1ns/1ps
module mon_frame_timeout #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  input  logic [TO_W-1:0] limit,
  output logic            at_limit
);

  logic [TO_W-1:0] cnt_q, cnt_d;
  logic [TO_W:0]   nxt;

  always_comb begin
    nxt   = {1'b0, cnt_q} + 1'b1;
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (tick && !nxt[TO_W]) cnt_d = nxt[TO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_limit = (limit != '0) && (nxt >= {1'b0, limit});

  AST_CLR_TICK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && tick)); // R11

endmodule

// File: rtl/mon_tx_handshake.sv
`timescale 1ns/1ps
module mon_tx_handshake
  import mon_tx_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int SLOT_POS   = 2,
  parameter int MR_POS     = 12,
  parameter int TO_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fsync,
  input  logic            tx_line_in,
  input  logic            rx_line_in,
  input  logic [TO_W-1:0] timeout_frames,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  output logic            in_ready,
  output logic            tx_pull,
  output logic            done_o,
  output logic            abort_o,
  output logic [1:0]      abort_cause
);

  localparam int CNT_W = $clog2(FRAME_BITS);

  logic             frame_start, in_slot, mr_strobe;
  logic [CNT_W-1:0] slot_pos;
  logic             coll, at_limit;
  logic             sending, mx_act;
  logic             tmr_clr, tmr_tick;

  hs_state_e    st_q, st_d;
  abort_cause_e cause_q, cause_d, hs_cause;
  logic [7:0]   byte_q, byte_d;
  logic         last_q, last_d;
  logic         mr_q, mr_d;
  logic         done_q, abort_q;
  logic         want, ack, hs_abort, fin;

  mon_frame_timer #(
    .FRAME_BITS(FRAME_BITS), .SLOT_POS(SLOT_POS), .MR_POS(MR_POS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .frame_start(frame_start), .in_slot(in_slot),
    .slot_pos(slot_pos), .mr_strobe(mr_strobe)
  );

  always_comb begin
    sending = (st_q == S_FIRST) || (st_q == S_TOGGLE) || (st_q == S_WAIT_DROP) ||
              (st_q == S_WAIT_RISE) || (st_q == S_HOLD) || (st_q == S_HOLD_ERR);
    mx_act  = sending && (st_q != S_TOGGLE);
  end

  mon_slot_driver #(.CNT_W(CNT_W)) u_drv (
    .in_slot(in_slot), .slot_pos(slot_pos), .sending(sending),
    .mx_act(mx_act), .byte_val(byte_q), .line_in(tx_line_in),
    .pull(tx_pull), .collision(coll)
  );

  mon_frame_timeout #(.TO_W(TO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tmr_tick),
    .limit(timeout_frames), .at_limit(at_limit)
  );

  // MR is latched once per frame; active when the line is low
  always_comb begin
    mr_d = mr_q;
    if (mr_strobe) mr_d = ~rx_line_in;
  end

  // handshake decisions are taken at each frame start
  always_comb begin
    st_d     = st_q;
    byte_d   = byte_q;
    last_d   = last_q;
    want     = 1'b0;
    ack      = 1'b0;
    hs_abort = 1'b0;
    hs_cause = CAUSE_HANDSHAKE;
    fin      = 1'b0;
    tmr_clr  = 1'b0;
    tmr_tick = 1'b0;
    if (frame_start && !coll) begin
      unique case (st_q)
        S_IDLE:      want = 1'b1;
        S_FIRST: begin
          if (mr_q) ack = 1'b1;
          else      tmr_tick = 1'b1;
        end
        S_TOGGLE: begin
          tmr_tick = 1'b1;
          if (mr_q) st_d = S_WAIT_DROP;
          else begin
            hs_abort = 1'b1;
            hs_cause = CAUSE_HANDSHAKE;
          end
        end
        S_WAIT_DROP: begin
          tmr_tick = 1'b1;
          if (!mr_q) st_d = S_WAIT_RISE;
        end
        S_WAIT_RISE: begin
          if (mr_q) ack = 1'b1;
          else begin
            hs_abort = 1'b1;
            hs_cause = CAUSE_FAR_ABORT;
          end
        end
        S_HOLD: begin
          if (mr_q) want = 1'b1;
          else      st_d = S_HOLD_ERR;
        end
        S_HOLD_ERR: begin
          hs_abort = 1'b1;
          hs_cause = mr_q ? CAUSE_HANDSHAKE : CAUSE_FAR_ABORT;
        end
        S_EOM1: st_d = S_EOM2;
        S_EOM2: begin
          fin  = 1'b1;
          st_d = S_IDLE;
        end
        default: st_d = S_IDLE;
      endcase
      if (ack) begin
        tmr_clr = 1'b1;
        if (last_q) st_d = S_EOM1;
        else begin
          want = 1'b1;
          st_d = S_HOLD;
        end
      end
      if (want && in_valid) begin
        byte_d  = in_data;
        last_d  = in_last;
        tmr_clr = 1'b1;
        st_d    = (st_q == S_IDLE) ? S_FIRST : S_TOGGLE;
      end
      if (tmr_tick && at_limit && !hs_abort) begin
        hs_abort = 1'b1;
        hs_cause = CAUSE_TIMEOUT;
      end
      if (hs_abort) st_d = S_IDLE;
    end
    if (coll) st_d = S_IDLE;
  end

  always_comb begin
    cause_d = cause_q;
    if (coll)          cause_d = CAUSE_COLLISION;
    else if (hs_abort) cause_d = hs_cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      byte_q  <= 8'hFF;
      last_q  <= 1'b0;
      mr_q    <= 1'b0;
      cause_q <= CAUSE_HANDSHAKE;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      byte_q  <= byte_d;
      last_q  <= last_d;
      mr_q    <= mr_d;
      cause_q <= cause_d;
      done_q  <= fin;
      abort_q <= coll | hs_abort;
    end
  end

  assign in_ready    = want;
  assign done_o      = done_q;
  assign abort_o     = abort_q;
  assign abort_cause = cause_q;

  AST_PULL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pull |-> in_slot); // R2
  AST_READY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> frame_start); // R13
  AST_COLLISION_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    coll |=> (abort_o && abort_cause == CAUSE_COLLISION)); // R10
  AST_FAR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && st_q == S_WAIT_RISE && !mr_q) |=> (abort_o && abort_cause == CAUSE_FAR_ABORT)); // R8
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o); // R12
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_o |-> $stable(abort_cause)); // R12
  AST_DONE_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && abort_o)); // R7

endmodule

// File: tb/mon_tx_handshake_tb.sv
`timescale 1ns/1ps
module mon_tx_handshake_tb;

  localparam int FRAME_BITS = 16;
  localparam int SLOT_POS   = 2;
  localparam int MR_POS     = 12;
  localparam int TO_W       = 8;
  localparam int NF         = 32;

  logic clk, rst_n, fsync, rx_line_in, far_pull;
  logic tx_line_in;
  logic [TO_W-1:0] timeout_frames;
  logic in_valid, in_last, in_ready, tx_pull, done_o, abort_o;
  logic [7:0] in_data;
  logic [1:0] abort_cause;

  assign tx_line_in = ~(tx_pull | far_pull);

  mon_tx_handshake #(
    .FRAME_BITS(FRAME_BITS), .SLOT_POS(SLOT_POS), .MR_POS(MR_POS), .TO_W(TO_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .tx_line_in(tx_line_in),
    .rx_line_in(rx_line_in), .timeout_frames(timeout_frames),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .tx_pull(tx_pull), .done_o(done_o),
    .abort_o(abort_o), .abort_cause(abort_cause)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic       mr_plan   [0:NF-1];
  int         coll_plan [0:NF-1];
  int         avail_plan[0:NF-1];
  logic [7:0] msg       [0:7];
  logic       msg_last  [0:7];
  int         msg_len, src_idx;

  logic [7:0] ob_byte [0:NF-1];
  logic       ob_mx   [0:NF-1];
  logic       ob_acc  [0:NF-1];
  logic       ob_out  [0:NF-1];
  logic [1:0] ob_cause[0:NF-1];
  int         ob_done [0:NF-1];
  int         ob_abort[0:NF-1];
  int         ready_bad;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prep(input int n);
    for (int i = 0; i < NF; i++) begin
      mr_plan[i] = 1'b0; coll_plan[i] = -1; avail_plan[i] = 99;
    end
    msg_len = n;
    src_idx = 0;
  endtask

  task automatic run_frames(input int n);
    for (int f = 0; f < n; f++) begin
      ob_byte[f] = 8'h00; ob_mx[f] = 1'b0; ob_acc[f] = 1'b0; ob_out[f] = 1'b0;
      ob_done[f] = 0; ob_abort[f] = 0;
      for (int b = 0; b < FRAME_BITS; b++) begin
        @(negedge clk);
        fsync      = (b == 0);
        rx_line_in = (b == MR_POS) ? ~mr_plan[f] : 1'b1;
        far_pull   = (b == coll_plan[f]);
        in_valid   = (src_idx < avail_plan[f]) && (src_idx < msg_len);
        in_data    = in_valid ? msg[src_idx] : 8'h00;
        in_last    = in_valid ? msg_last[src_idx] : 1'b0;
        #1;
        if (b >= SLOT_POS && b < SLOT_POS + 8) ob_byte[f][7 - (b - SLOT_POS)] = tx_line_in;
        else if (b == SLOT_POS + 8) ob_mx[f] = !tx_line_in;
        else if (tx_pull) ob_out[f] = 1'b1;
        if (done_o)  ob_done[f]++;
        if (abort_o) ob_abort[f]++;
        if (in_ready && b != 0) ready_bad++;
        if (in_ready && in_valid) begin
          ob_acc[f] = 1'b1;
          src_idx++;
        end
      end
      ob_cause[f] = abort_cause;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; fsync = 1'b0; rx_line_in = 1'b1; far_pull = 1'b0;
    in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0; timeout_frames = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 reset tx_pull", tx_pull, 1'b0);
    chk("R1 reset done", done_o, 1'b0);
    chk("R1 reset abort", abort_o, 1'b0);
    chk("R1 reset cause", abort_cause, 2'd0);
    chk("R1 reset in_ready", in_ready, 1'b0);
  endtask

  task automatic t_single;
    prep(1); msg[0] = 8'hA5; msg_last[0] = 1'b1; timeout_frames = '0;
    mr_plan[1] = 1'b1;
    run_frames(5);
    chk("R3 accepted in frame 0", ob_acc[0], 1'b1);
    chk("R3 byte in frame 0", ob_byte[0], 8'hA5);
    chk("R2 MX active frame 0", ob_mx[0], 1'b1);
    chk("R4 resent frame 1", {ob_byte[1], 7'd0, ob_mx[1]}, {8'hA5, 8'h01});
    chk("R7 released frame 2", {ob_byte[2], 7'd0, ob_mx[2]}, {8'hFF, 8'h00});
    chk("R7 released frame 3", {ob_byte[3], 7'd0, ob_mx[3]}, {8'hFF, 8'h00});
    chk("R7 no done early", ob_done[3], 0);
    chk("R7 done once frame 4", ob_done[4], 1);
    chk("R7 no abort", ob_abort[4], 0);
  endtask

  task automatic t_multi;
    prep(3);
    msg[0] = 8'h10; msg_last[0] = 1'b0;
    msg[1] = 8'h20; msg_last[1] = 1'b0;
    msg[2] = 8'h30; msg_last[2] = 1'b1;
    mr_plan[0] = 1; mr_plan[1] = 1; mr_plan[2] = 0; mr_plan[3] = 1;
    mr_plan[4] = 1; mr_plan[5] = 0; mr_plan[6] = 1;
    run_frames(10);
    chk("R6 first ack -> toggle frame 1", {ob_byte[1], 7'd0, ob_mx[1]}, {8'h20, 8'h00});
    chk("R5 MX active again frame 2", {ob_byte[2], 7'd0, ob_mx[2]}, {8'h20, 8'h01});
    chk("R6 drop not yet ack frame 3", {ob_byte[3], 7'd0, ob_mx[3]}, {8'h20, 8'h01});
    chk("R6 drop+rise ack -> toggle frame 4", {ob_byte[4], 7'd0, ob_mx[4]}, {8'h30, 8'h00});
    chk("R5 frame 5", {ob_byte[5], 7'd0, ob_mx[5]}, {8'h30, 8'h01});
    chk("R13 accepts", {ob_acc[0], ob_acc[1], ob_acc[2], ob_acc[4]}, 4'b1101);
    chk("R7 EOM frames", {ob_mx[7], ob_mx[8], ob_byte[8]}, {2'b00, 8'hFF});
    chk("R7 done frame 9", ob_done[9], 1);
    for (int f = 0; f < 10; f++) chk("R2 no pull outside slot", ob_out[f], 1'b0);
  endtask

  task automatic t_stall;
    prep(2);
    msg[0] = 8'h11; msg_last[0] = 1'b0;
    msg[1] = 8'h22; msg_last[1] = 1'b1;
    for (int f = 0; f < 5; f++) avail_plan[f] = 1;
    for (int f = 0; f < 12; f++) mr_plan[f] = 1'b1;
    mr_plan[6] = 1'b0;
    run_frames(11);
    for (int f = 1; f < 5; f++)
      chk("R4 stall repeats byte", {ob_byte[f], 7'd0, ob_mx[f]}, {8'h11, 8'h01});
    chk("R5 toggle after stall", {ob_byte[5], 7'd0, ob_mx[5]}, {8'h22, 8'h00});
    chk("R7 done after stall", ob_done[10], 1);
  endtask

  task automatic t_collision;
    prep(1); msg[0] = 8'hFF; msg_last[0] = 1'b1;
    coll_plan[0] = SLOT_POS + 3;
    run_frames(3);
    chk("R10 abort in frame 0", ob_abort[0], 1);
    chk("R10 cause collision", ob_cause[0], 2'd1);
    chk("R10 line released after hit", {ob_byte[0], 7'd0, ob_mx[0]}, {8'hEF, 8'h00});
    chk("R10 not resent", {ob_byte[1], 7'd0, ob_mx[1]}, {8'hFF, 8'h00});
    chk("R12 cause held", ob_cause[2], 2'd1);
  endtask

  task automatic t_toggle_err;
    prep(2);
    msg[0] = 8'hD4; msg_last[0] = 1'b0;
    msg[1] = 8'hE5; msg_last[1] = 1'b1;
    mr_plan[0] = 1'b1; mr_plan[1] = 1'b0;
    run_frames(3);
    chk("R12 old cause until new abort", ob_cause[1], 2'd1);
    chk("R9 abort frame 2", ob_abort[2], 1);
    chk("R9 cause handshake", ob_cause[2], 2'd0);
  endtask

  task automatic t_far_abort;
    prep(2);
    msg[0] = 8'hA1; msg_last[0] = 1'b0;
    msg[1] = 8'hB2; msg_last[1] = 1'b1;
    mr_plan[0] = 1; mr_plan[1] = 1; mr_plan[2] = 0; mr_plan[3] = 0;
    run_frames(5);
    chk("R8 no abort after one drop", ob_abort[3], 0);
    chk("R8 abort frame 4", ob_abort[4], 1);
    chk("R8 cause far-end", ob_cause[4], 2'd3);
    chk("R8 line released", {ob_byte[4], 7'd0, ob_mx[4]}, {8'hFF, 8'h00});
  endtask

  task automatic t_hold_err;
    prep(1); msg[0] = 8'hC3; msg_last[0] = 1'b0;
    mr_plan[0] = 1; mr_plan[1] = 0; mr_plan[2] = 1;
    run_frames(4);
    chk("R4 stall frame 2", {ob_byte[2], 7'd0, ob_mx[2]}, {8'hC3, 8'h01});
    chk("R9 hold drop abort frame 3", ob_abort[3], 1);
    chk("R9 hold drop cause", ob_cause[3], 2'd0);
  endtask

  task automatic t_timeout;
    prep(1); msg[0] = 8'h5A; msg_last[0] = 1'b1;
    timeout_frames = 8'd3;
    run_frames(4);
    chk("R11 no abort before limit", ob_abort[2], 0);
    chk("R11 abort at limit", ob_abort[3], 1);
    chk("R11 cause time-out", ob_cause[3], 2'd2);
  endtask

  task automatic t_timeout_restart;
    prep(2);
    msg[0] = 8'h6B; msg_last[0] = 1'b0;
    msg[1] = 8'h7C; msg_last[1] = 1'b1;
    for (int f = 1; f < 8; f++) mr_plan[f] = 1'b1;
    timeout_frames = 8'd3;
    run_frames(6);
    chk("R11 restart frame 3", ob_abort[3], 0);
    chk("R11 restart frame 4", ob_abort[4], 0);
    chk("R11 abort after restart", ob_abort[5], 1);
    chk("R11 restart cause", ob_cause[5], 2'd2);
  endtask

  task automatic t_timeout_off;
    int total;
    prep(1); msg[0] = 8'h77; msg_last[0] = 1'b1;
    timeout_frames = '0;
    run_frames(20);
    total = 0;
    for (int f = 0; f < 20; f++) total += ob_abort[f];
    chk("R11 limit 0 never aborts", total, 0);
    chk("R4 still resent frame 19", {ob_byte[19], 7'd0, ob_mx[19]}, {8'h77, 8'h01});
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    ready_bad = 0;
    t_reset();
    t_single();
    t_multi();
    t_stall();
    t_collision();
    t_toggle_err();
    t_far_abort();
    t_hold_err();
    t_timeout();
    t_timeout_restart();
    t_timeout_off();
    chk("R13 in_ready only at frame start", ready_bad, 0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

endmodule